// File: doc/BRIEF.md
# Two-Wide Register Renamer with Branch Checkpoints

This block sits between decode and dispatch in an out-of-order core. Each cycle it accepts a group of up to two instructions. Every destination register gets a fresh physical register from a circular free list. Every source operand is translated to the physical register that holds its newest value. For each destination, the block also returns the physical register that the destination previously mapped to. The reorder buffer stores that value and hands it back through the free port when the instruction commits. Only then does the register rejoin the free list.

When the second instruction of a group reads or writes the architectural register that the first instruction writes, the second one sees the first one's new physical register. A group may end in a predicted branch. In that case the map table and the free-list read pointer, as they stand after the group, are saved into an idle checkpoint slot, and the slot number is returned as a tag. On a mispredict, the saved copy replaces the live table and the read pointer is rewound. Registers that were returned at the tail in the meantime stay in the list. The restored slot, and every slot taken after it, become idle again.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register a maps to physical register a, renReady is high with no request pending, and the free list holds physical registers 8 to 31, to be handed out in ascending order.
- R2: In an accepted group, a lane with laneVld, laneDstVld and a nonzero destination receives the next free-list entry on lanePdst. Lane 0 takes its entry before lane 1, and the two lanes never receive the same register. Lane i occupies bits of width ARCH_W or PHYS_W at offset i times that width in every packed lane port.
- R3: Sources are translated through the map table, which includes every destination renamed in earlier accepted groups.
- R4: laneOldPdst of a renaming lane is the physical register its destination mapped to before the group.
- R5: A lane 1 source equal to a renamed lane 0 destination is translated to lane 0's new physical register.
- R6: When both lanes rename the same destination, lane 1's old mapping is lane 0's new register, and later groups see lane 1's register.
- R7: Architectural register 0 is never renamed. A source 0 reads physical 0. A lane whose destination is 0, or that has no destination, outputs 0 for both lanePdst and laneOldPdst and consumes no free-list entry.
- R8: Registers presented on the free port are appended at the tail in lane order, lane 0 first, in any cycle. They are handed out only after the entries already in the list. A freed value of 0 is ignored.
- R9: renReady is low when the list holds fewer entries than the group needs. Registers freed in the same cycle do not count. A group is consumed only when renValid and renReady are both high.
- R10: An accepted group with brReq saves the map as it stands after the group and returns on brTag the lowest-numbered idle checkpoint slot. renReady is low when brReq is set and all slots are busy.
- R11: A restore returns the map table and the free-list read pointer to the saved copy. Registers handed out after the branch are therefore handed out again in the same order, while tail frees are kept.
- R12: A restore makes its own slot idle, together with every slot taken after it. A release makes exactly the named slot idle.
- R13: renReady is low in any cycle where restoreVld is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| renValid | input | 1 | Rename group offered |
| renReady | output | 1 | Group can be accepted this cycle |
| laneVld | input | 2 | Lane holds an instruction |
| laneDstVld | input | 2 | Lane writes a destination |
| laneDst | input | 2*ARCH_W | Architectural destinations |
| laneSrcA | input | 2*ARCH_W | First architectural sources |
| laneSrcB | input | 2*ARCH_W | Second architectural sources |
| brReq | input | 1 | Group ends in a predicted branch |
| brTag | output | SNAP_W | Checkpoint slot taken by the branch |
| lanePdst | output | 2*PHYS_W | New physical destinations |
| laneOldPdst | output | 2*PHYS_W | Previous physical mappings of the destinations |
| lanePsrcA | output | 2*PHYS_W | Translated first sources |
| lanePsrcB | output | 2*PHYS_W | Translated second sources |
| freeVld | input | 2 | Free-port lane valid |
| freeReg | input | 2*PHYS_W | Physical registers returned at commit |
| restoreVld | input | 1 | Mispredict: restore a checkpoint |
| restoreTag | input | SNAP_W | Slot to restore |
| releaseVld | input | 1 | Branch resolved correctly |
| releaseTag | input | SNAP_W | Slot to release |

## Verification
The bench uses the default build: 8 architectural registers, 32 physical registers and 4 checkpoint slots. With so few registers, the bench can sweep every pair of lane 0 and lane 1 destinations, so every bypass and same-destination overlap is hit. Twelve two-destination groups drain the pool, so both the stall and the single-entry edge case are reached quickly. Four branches fill every checkpoint slot, so the full-slot stall, squashing of younger slots and lowest-slot reuse can each be driven directly, with expected values tracked arithmetically in the bench.

// File: rtl/rename_pkg.sv
package rename_pkg;

  typedef struct packed {
    logic fire;     // group accepted this cycle
    logic take0;    // lane 0 pops a free register
    logic take1;    // lane 1 pops a free register
    logic snapWr;   // save checkpoint of post-group map
    logic restore;  // reload map and head from a checkpoint
  } renStrobe_t;

endpackage

// File: rtl/rename_ctrl.sv
module rename_ctrl
  import rename_pkg::*;
#(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 32,
  parameter int NUM_SNAP = 4,
  localparam int ARCH_W = $clog2(NUM_ARCH),
  localparam int SNAP_W = $clog2(NUM_SNAP),
  localparam int PTR_W  = $clog2(NUM_PHYS) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                renValid,
  input  logic [1:0]          laneVld,
  input  logic [1:0]          laneDstVld,
  input  logic [2*ARCH_W-1:0] laneDst,
  input  logic                brReq,
  input  logic                restoreVld,
  input  logic [SNAP_W-1:0]   restoreTag,
  input  logic                releaseVld,
  input  logic [SNAP_W-1:0]   releaseTag,
  input  logic [PTR_W-1:0]    flCount,
  output logic                renReady,
  output renStrobe_t          strb,
  output logic [SNAP_W-1:0]   snapIdx
);

  logic [NUM_SNAP-1:0] busy;
  logic [NUM_SNAP-1:0] clrMask;
  logic [NUM_SNAP-1:0] setMask;
  logic [NUM_SNAP-1:0] age [NUM_SNAP];  // age[k][j]: slot j taken after slot k
  logic [1:0]          want;
  logic [1:0]          need;
  logic                anyFree;
  logic                fire;

  always_comb begin
    want[0] = laneVld[0] & laneDstVld[0] & (|laneDst[ARCH_W-1:0]);
    want[1] = laneVld[1] & laneDstVld[1] & (|laneDst[2*ARCH_W-1:ARCH_W]);
    need    = {1'b0, want[0]} + {1'b0, want[1]};
  end

  // lowest idle checkpoint slot
  always_comb begin
    snapIdx = '0;
    anyFree = 1'b0;
    for (int k = NUM_SNAP - 1; k >= 0; k--) begin
      if (!busy[k]) begin
        snapIdx = SNAP_W'(k);
        anyFree = 1'b1;
      end
    end
  end

  always_comb begin
    renReady     = !restoreVld && (flCount >= PTR_W'(need)) && (!brReq || anyFree);
    fire         = renValid && renReady;
    strb.fire    = fire;
    strb.take0   = fire & want[0];
    strb.take1   = fire & want[1];
    strb.snapWr  = fire & brReq;
    strb.restore = restoreVld;
  end

  always_comb begin
    clrMask = '0;
    if (restoreVld) clrMask = age[restoreTag] | (NUM_SNAP'(1) << restoreTag);
    if (releaseVld) clrMask = clrMask | (NUM_SNAP'(1) << releaseTag);
    setMask = strb.snapWr ? (NUM_SNAP'(1) << snapIdx) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= '0;
      for (int k = 0; k < NUM_SNAP; k++) age[k] <= '0;
    end else begin
      busy <= (busy & ~clrMask) | setMask;
      if (strb.snapWr) begin
        for (int j = 0; j < NUM_SNAP; j++) begin
          if (SNAP_W'(j) == snapIdx) age[j] <= '0;
          else                       age[j][snapIdx] <= busy[j];
        end
      end
    end
  end

endmodule

// File: rtl/rename_dpath.sv
module rename_dpath
  import rename_pkg::*;
#(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 32,
  parameter int NUM_SNAP = 4,
  localparam int ARCH_W = $clog2(NUM_ARCH),
  localparam int PHYS_W = $clog2(NUM_PHYS),
  localparam int SNAP_W = $clog2(NUM_SNAP),
  localparam int PTR_W  = PHYS_W + 1,
  localparam int INIT_FREE = NUM_PHYS - NUM_ARCH
) (
  input  logic                clk,
  input  logic                rstN,
  input  renStrobe_t          strb,
  input  logic [SNAP_W-1:0]   snapIdx,
  input  logic [SNAP_W-1:0]   restoreTag,
  input  logic [2*ARCH_W-1:0] laneDst,
  input  logic [2*ARCH_W-1:0] laneSrcA,
  input  logic [2*ARCH_W-1:0] laneSrcB,
  input  logic [1:0]          freeVld,
  input  logic [2*PHYS_W-1:0] freeReg,
  output logic [2*PHYS_W-1:0] lanePdst,
  output logic [2*PHYS_W-1:0] laneOldPdst,
  output logic [2*PHYS_W-1:0] lanePsrcA,
  output logic [2*PHYS_W-1:0] lanePsrcB,
  output logic [PTR_W-1:0]    flCount
);

  logic [PHYS_W-1:0] mapTab  [NUM_ARCH];
  logic [PHYS_W-1:0] nextTab [NUM_ARCH];
  logic [PHYS_W-1:0] snapTab [NUM_SNAP][NUM_ARCH];
  logic [PTR_W-1:0]  snapHead [NUM_SNAP];
  logic [PHYS_W-1:0] ring [NUM_PHYS];
  logic [PTR_W-1:0]  head, tail, headNext, tailNext;

  logic [ARCH_W-1:0] dst0, dst1, srcA0, srcA1, srcB0, srcB1;
  logic [PHYS_W-1:0] pdst0, pdst1, old0, old1;
  logic [PHYS_W-1:0] free0, free1;
  logic [PHYS_W-1:0] hIdx0, hIdx1, tIdx0, tIdx1;
  logic              push0, push1;

  assign dst0  = laneDst[ARCH_W-1:0];
  assign dst1  = laneDst[2*ARCH_W-1:ARCH_W];
  assign srcA0 = laneSrcA[ARCH_W-1:0];
  assign srcA1 = laneSrcA[2*ARCH_W-1:ARCH_W];
  assign srcB0 = laneSrcB[ARCH_W-1:0];
  assign srcB1 = laneSrcB[2*ARCH_W-1:ARCH_W];
  assign free0 = freeReg[PHYS_W-1:0];
  assign free1 = freeReg[2*PHYS_W-1:PHYS_W];

  // allocation from the head
  always_comb begin
    hIdx0    = head[PHYS_W-1:0];
    hIdx1    = hIdx0 + PHYS_W'(1);
    pdst0    = strb.take0 ? ring[hIdx0] : '0;
    pdst1    = strb.take1 ? (strb.take0 ? ring[hIdx1] : ring[hIdx0]) : '0;
    headNext = head + PTR_W'(strb.take0) + PTR_W'(strb.take1);
  end

  // lookup with same-group forwarding from lane 0 to lane 1
  always_comb begin
    old0 = strb.take0 ? mapTab[dst0] : '0;
    old1 = '0;
    if (strb.take1) old1 = (strb.take0 && dst1 == dst0) ? pdst0 : mapTab[dst1];
    lanePsrcA[PHYS_W-1:0]        = mapTab[srcA0];
    lanePsrcB[PHYS_W-1:0]        = mapTab[srcB0];
    lanePsrcA[2*PHYS_W-1:PHYS_W] = (strb.take0 && srcA1 == dst0) ? pdst0 : mapTab[srcA1];
    lanePsrcB[2*PHYS_W-1:PHYS_W] = (strb.take0 && srcB1 == dst0) ? pdst0 : mapTab[srcB1];
    lanePdst    = {pdst1, pdst0};
    laneOldPdst = {old1, old0};
  end

  always_comb begin
    nextTab = mapTab;
    if (strb.take0) nextTab[dst0] = pdst0;
    if (strb.take1) nextTab[dst1] = pdst1;
  end

  // returns at the tail
  always_comb begin
    push0    = freeVld[0] && (free0 != '0);
    push1    = freeVld[1] && (free1 != '0);
    tIdx0    = tail[PHYS_W-1:0];
    tIdx1    = push0 ? tIdx0 + PHYS_W'(1) : tIdx0;
    tailNext = tail + PTR_W'(push0) + PTR_W'(push1);
    flCount  = tail - head;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < NUM_ARCH; a++) mapTab[a] <= PHYS_W'(a);
      for (int s = 0; s < NUM_SNAP; s++) begin
        snapHead[s] <= '0;
        for (int a = 0; a < NUM_ARCH; a++) snapTab[s][a] <= '0;
      end
      for (int i = 0; i < NUM_PHYS; i++)
        ring[i] <= (i < INIT_FREE) ? PHYS_W'(NUM_ARCH + i) : '0;
      head <= '0;
      tail <= PTR_W'(INIT_FREE);
    end else begin
      if (strb.restore) begin
        for (int a = 0; a < NUM_ARCH; a++) mapTab[a] <= snapTab[restoreTag][a];
        head <= snapHead[restoreTag];
      end else if (strb.fire) begin
        for (int a = 0; a < NUM_ARCH; a++) mapTab[a] <= nextTab[a];
        head <= headNext;
      end
      if (strb.snapWr) begin
        for (int a = 0; a < NUM_ARCH; a++) snapTab[snapIdx][a] <= nextTab[a];
        snapHead[snapIdx] <= headNext;
      end
      if (push0) ring[tIdx0] <= free0;
      if (push1) ring[tIdx1] <= free1;
      tail <= tailNext;
    end
  end

endmodule

// File: rtl/reg_rename.sv
module reg_rename
  import rename_pkg::*;
#(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 32,
  parameter int NUM_SNAP = 4,
  localparam int ARCH_W = $clog2(NUM_ARCH),
  localparam int PHYS_W = $clog2(NUM_PHYS),
  localparam int SNAP_W = $clog2(NUM_SNAP)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                renValid,
  output logic                renReady,
  input  logic [1:0]          laneVld,
  input  logic [1:0]          laneDstVld,
  input  logic [2*ARCH_W-1:0] laneDst,
  input  logic [2*ARCH_W-1:0] laneSrcA,
  input  logic [2*ARCH_W-1:0] laneSrcB,
  input  logic                brReq,
  output logic [SNAP_W-1:0]   brTag,
  output logic [2*PHYS_W-1:0] lanePdst,
  output logic [2*PHYS_W-1:0] laneOldPdst,
  output logic [2*PHYS_W-1:0] lanePsrcA,
  output logic [2*PHYS_W-1:0] lanePsrcB,
  input  logic [1:0]          freeVld,
  input  logic [2*PHYS_W-1:0] freeReg,
  input  logic                restoreVld,
  input  logic [SNAP_W-1:0]   restoreTag,
  input  logic                releaseVld,
  input  logic [SNAP_W-1:0]   releaseTag
);

  renStrobe_t        strb;
  logic [SNAP_W-1:0] snapIdx;
  logic [PHYS_W:0]   flCount;

  rename_ctrl #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .NUM_SNAP(NUM_SNAP)) u_ctrl (
    .clk(clk), .rstN(rstN), .renValid(renValid), .laneVld(laneVld),
    .laneDstVld(laneDstVld), .laneDst(laneDst), .brReq(brReq),
    .restoreVld(restoreVld), .restoreTag(restoreTag),
    .releaseVld(releaseVld), .releaseTag(releaseTag), .flCount(flCount),
    .renReady(renReady), .strb(strb), .snapIdx(snapIdx)
  );

  rename_dpath #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .NUM_SNAP(NUM_SNAP)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .snapIdx(snapIdx), .restoreTag(restoreTag),
    .laneDst(laneDst), .laneSrcA(laneSrcA), .laneSrcB(laneSrcB),
    .freeVld(freeVld), .freeReg(freeReg), .lanePdst(lanePdst),
    .laneOldPdst(laneOldPdst), .lanePsrcA(lanePsrcA), .lanePsrcB(lanePsrcB),
    .flCount(flCount)
  );

  assign brTag = snapIdx;

endmodule

// File: rtl/rename_chk.sv
module rename_chk #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 32,
  parameter int NUM_SNAP = 4,
  localparam int ARCH_W = $clog2(NUM_ARCH),
  localparam int PHYS_W = $clog2(NUM_PHYS),
  localparam int SNAP_W = $clog2(NUM_SNAP)
) (
  input logic                clk,
  input logic                rstN,
  input logic                renValid,
  input logic                renReady,
  input logic [1:0]          laneVld,
  input logic [1:0]          laneDstVld,
  input logic [2*ARCH_W-1:0] laneDst,
  input logic [2*ARCH_W-1:0] laneSrcA,
  input logic [2*PHYS_W-1:0] lanePdst,
  input logic [2*PHYS_W-1:0] laneOldPdst,
  input logic [2*PHYS_W-1:0] lanePsrcA,
  input logic                restoreVld,
  input logic [PHYS_W:0]     flCount
);

  logic              acc;
  logic [ARCH_W-1:0] d0, d1;
  logic              ren0, ren1;

  assign acc  = renValid && renReady;
  assign d0   = laneDst[ARCH_W-1:0];
  assign d1   = laneDst[2*ARCH_W-1:ARCH_W];
  assign ren0 = laneVld[0] && laneDstVld[0] && d0 != '0;
  assign ren1 = laneVld[1] && laneDstVld[1] && d1 != '0;

  a_r7_zero_src: assert property (@(posedge clk) disable iff (!rstN)
    (acc && laneVld[0] && laneSrcA[ARCH_W-1:0] == '0) |-> lanePsrcA[PHYS_W-1:0] == '0);

  a_r7_zero_dst: assert property (@(posedge clk) disable iff (!rstN)
    (acc && laneVld[0] && laneDstVld[0] && d0 == '0) |->
      (lanePdst[PHYS_W-1:0] == '0 && laneOldPdst[PHYS_W-1:0] == '0));

  a_r2_distinct: assert property (@(posedge clk) disable iff (!rstN)
    (acc && ren0 && ren1) |->
      (lanePdst[PHYS_W-1:0] != lanePdst[2*PHYS_W-1:PHYS_W] &&
       lanePdst[PHYS_W-1:0] != '0 && lanePdst[2*PHYS_W-1:PHYS_W] != '0));

  a_r5_group_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (acc && ren0 && laneVld[1] && laneSrcA[2*ARCH_W-1:ARCH_W] == d0) |->
      lanePsrcA[2*PHYS_W-1:PHYS_W] == lanePdst[PHYS_W-1:0]);

  a_r6_old_chain: assert property (@(posedge clk) disable iff (!rstN)
    (acc && ren0 && ren1 && d1 == d0) |->
      laneOldPdst[2*PHYS_W-1:PHYS_W] == lanePdst[PHYS_W-1:0]);

  a_r13_restore_stall: assert property (@(posedge clk) disable iff (!rstN)
    restoreVld |-> !renReady);

  a_r9_pool_bound: assert property (@(posedge clk) disable iff (!rstN)
    flCount <= (PHYS_W+1)'(NUM_PHYS - 1));

  a_r9_empty_stall: assert property (@(posedge clk) disable iff (!rstN)
    (flCount == '0 && ren0) |-> !renReady);

endmodule

bind reg_rename rename_chk #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .NUM_SNAP(NUM_SNAP)) u_chk (
  .clk(clk), .rstN(rstN), .renValid(renValid), .renReady(renReady),
  .laneVld(laneVld), .laneDstVld(laneDstVld), .laneDst(laneDst),
  .laneSrcA(laneSrcA), .lanePdst(lanePdst), .laneOldPdst(laneOldPdst),
  .lanePsrcA(lanePsrcA), .restoreVld(restoreVld), .flCount(flCount)
);

// File: tb/sim_reg_rename.sv
`timescale 1ns/1ps
module sim_reg_rename;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       renValid = 1'b0;
  logic       renReady;
  logic [1:0] laneVld = '0, laneDstVld = '0;
  logic [5:0] laneDst = '0, laneSrcA = '0, laneSrcB = '0;
  logic       brReq = 1'b0;
  logic [1:0] brTag;
  logic [9:0] lanePdst, laneOldPdst, lanePsrcA, lanePsrcB;
  logic [1:0] freeVld = '0;
  logic [9:0] freeReg = '0;
  logic       restoreVld = 1'b0;
  logic [1:0] restoreTag = '0;
  logic       releaseVld = 1'b0;
  logic [1:0] releaseTag = '0;

  always #2 clk = ~clk;

  reg_rename u0 (
    .clk(clk), .rstN(rstN), .renValid(renValid), .renReady(renReady),
    .laneVld(laneVld), .laneDstVld(laneDstVld), .laneDst(laneDst),
    .laneSrcA(laneSrcA), .laneSrcB(laneSrcB), .brReq(brReq), .brTag(brTag),
    .lanePdst(lanePdst), .laneOldPdst(laneOldPdst), .lanePsrcA(lanePsrcA),
    .lanePsrcB(lanePsrcB), .freeVld(freeVld), .freeReg(freeReg),
    .restoreVld(restoreVld), .restoreTag(restoreTag),
    .releaseVld(releaseVld), .releaseTag(releaseTag)
  );

  // reference state
  int mTab[8];
  int mRing[32];
  int mHead, mTail;
  int mSnapTab[4][8];
  int mSnapHead[4];
  bit mBusy[4];
  bit mAge[4][4];
  int pq[1024];
  int pqH, pqT;
  int nChk, nFail;

  // staged stimulus
  bit gRv, gBr, gAuto, gRs, gRl;
  bit [1:0] gV, gDv, gFv;
  int gD0, gD1, gA0, gA1, gB0, gB1, gF0, gF1, gRt, gLt;

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    gRv = 0; gBr = 0; gAuto = 0; gRs = 0; gRl = 0;
    gV = 0; gDv = 0; gFv = 0;
    gD0 = 0; gD1 = 0; gA0 = 0; gA1 = 0; gB0 = 0; gB1 = 0;
    gF0 = 0; gF1 = 0; gRt = 0; gLt = 0;
  endtask

  task automatic step(string tag);
    int tmp[8];
    int cnt, need, slot, p0, p1, o0, o1, f0, f1;
    bit t0, t1, expRdy;
    bit [1:0] fv;
    bit [3:0] clrM;
    string lr;
    f0 = gF0; f1 = gF1; fv = gFv;
    if (gAuto) begin
      fv = 0;
      if (pqH < pqT) begin fv[0] = 1; f0 = pq[pqH]; pqH++; end
      if (pqH < pqT) begin fv[1] = 1; f1 = pq[pqH]; pqH++; end
    end
    @(negedge clk);
    renValid = gRv; laneVld = gV; laneDstVld = gDv; brReq = gBr;
    laneDst  = {3'(gD1), 3'(gD0)};
    laneSrcA = {3'(gA1), 3'(gA0)};
    laneSrcB = {3'(gB1), 3'(gB0)};
    freeVld = fv; freeReg = {5'(f1), 5'(f0)};
    restoreVld = gRs; restoreTag = 2'(gRt);
    releaseVld = gRl; releaseTag = 2'(gLt);
    #1;
    cnt = mTail - mHead;
    t0 = gV[0] && gDv[0] && gD0 != 0;
    t1 = gV[1] && gDv[1] && gD1 != 0;
    need = int'(t0) + int'(t1);
    slot = -1;
    for (int k = 3; k >= 0; k--) if (!mBusy[k]) slot = k;
    expRdy = !gRs && cnt >= need && (!gBr || slot >= 0);
    lr = gRs ? "R13" : ((gBr && slot < 0) ? "R10" : "R9");
    chk(tag != "" ? tag : lr, int'(renReady), int'(expRdy));
    if (gRv && expRdy) begin
      tmp = mTab;
      p0 = t0 ? mRing[mHead % 32] : 0;
      o0 = t0 ? tmp[gD0] : 0;
      if (gV[0]) begin
        chk(tag != "" ? tag : (t0 ? "R2" : "R7"), int'(lanePdst[4:0]), p0);
        chk(tag != "" ? tag : (t0 ? "R4" : "R7"), int'(laneOldPdst[4:0]), o0);
        chk(tag != "" ? tag : (gA0 == 0 ? "R7" : "R3"), int'(lanePsrcA[4:0]), tmp[gA0]);
        chk(tag != "" ? tag : (gB0 == 0 ? "R7" : "R3"), int'(lanePsrcB[4:0]), tmp[gB0]);
      end
      if (t0) tmp[gD0] = p0;
      p1 = t1 ? mRing[(mHead + int'(t0)) % 32] : 0;
      o1 = t1 ? tmp[gD1] : 0;
      if (gV[1]) begin
        chk(tag != "" ? tag : (t1 ? "R2" : "R7"), int'(lanePdst[9:5]), p1);
        chk(tag != "" ? tag : ((t0 && t1 && gD1 == gD0) ? "R6" : "R4"), int'(laneOldPdst[9:5]), o1);
        chk(tag != "" ? tag : ((t0 && gA1 == gD0) ? "R5" : "R3"), int'(lanePsrcA[9:5]), tmp[gA1]);
        chk(tag != "" ? tag : ((t0 && gB1 == gD0) ? "R5" : "R3"), int'(lanePsrcB[9:5]), tmp[gB1]);
      end
      if (t1) tmp[gD1] = p1;
      mTab = tmp;
      mHead += need;
      if (t0) begin pq[pqT] = o0; pqT++; end
      if (t1) begin pq[pqT] = o1; pqT++; end
      if (gBr) begin
        chk(tag != "" ? tag : "R10", int'(brTag), slot);
        mSnapTab[slot] = tmp;
        mSnapHead[slot] = mHead;
        for (int j = 0; j < 4; j++) begin
          mAge[j][slot] = mBusy[j];
          mAge[slot][j] = 0;
        end
      end
    end
    // frees at the tail, lane 0 first; zero ignored (R8)
    if (fv[0] && f0 != 0) begin mRing[mTail % 32] = f0; mTail++; end
    if (fv[1] && f1 != 0) begin mRing[mTail % 32] = f1; mTail++; end
    clrM = 0;
    if (gRs) begin
      mTab = mSnapTab[gRt];
      mHead = mSnapHead[gRt];
      clrM[gRt] = 1;
      for (int j = 0; j < 4; j++) if (mAge[gRt][j]) clrM[j] = 1;
    end
    if (gRl) clrM[gLt] = 1;
    for (int j = 0; j < 4; j++) if (clrM[j]) mBusy[j] = 0;
    if (gRv && expRdy && gBr) mBusy[slot] = 1;
    @(posedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    nChk = 0; nFail = 0; pqH = 0; pqT = 0;
    for (int a = 0; a < 8; a++) mTab[a] = a;
    for (int i = 0; i < 32; i++) mRing[i] = (i < 24) ? 8 + i : 0;
    mHead = 0; mTail = 24;
    for (int k = 0; k < 4; k++) begin
      mBusy[k] = 0; mSnapHead[k] = 0;
      for (int j = 0; j < 4; j++) mAge[k][j] = 0;
      for (int a = 0; a < 8; a++) mSnapTab[k][a] = 0;
    end
    clr();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1 chk("R1", int'(renReady), 1);

    // R1: identity map read on every source, first allocations 8 and 9
    for (int s = 0; s < 8; s++) begin
      clr(); gRv = 1; gV = 2'b11;
      gA0 = s; gB0 = 7 - s; gA1 = (s + 3) % 8; gB1 = s;
      step("R1");
    end
    clr(); gRv = 1; gV = 2'b11; gDv = 2'b11; gD0 = 3; gD1 = 5; gA1 = 3;
    step("R1");

    // R2..R7: every destination pair, sources aimed at overlaps
    for (int d0 = 0; d0 < 8; d0++) begin
      for (int d1 = 0; d1 < 8; d1++) begin
        clr(); gRv = 1; gV = 2'b11; gDv = 2'b11; gAuto = 1;
        gD0 = d0; gD1 = d1;
        gA0 = d1; gB0 = 7 - d0; gA1 = d0; gB1 = (d0 + d1) % 8;
        step("");
      end
    end
    // lane-valid and destination-valid mixes
    for (int k = 0; k < 16; k++) begin
      clr(); gRv = 1; gAuto = 1;
      gV = 2'(k % 4); gDv = 2'(k / 4);
      gD0 = k % 8; gD1 = (k + 1) % 8; gA1 = k % 8; gB0 = (k + 5) % 8;
      step("");
    end

    // R8: zero on the free port is ignored, renames continue
    clr(); gRv = 1; gV = 2'b01; gDv = 2'b01; gD0 = 4; gFv = 2'b11;
    step("R8");
    for (int i = 0; i < 3; i++) begin
      clr(); gRv = 1; gV = 2'b11; gDv = 2'b11; gD0 = 2 + i; gD1 = 6 - i;
      step("R8");
    end

    // R9: exhaust the pool without frees
    for (int i = 0; i < 20; i++) begin
      clr(); gRv = 1; gV = 2'b11; gDv = 2'b11;
      gD0 = 1 + i % 7; gD1 = 1 + (i + 3) % 7; gA1 = gD0;
      step("");
    end
    for (int i = 0; i < 3; i++) begin
      clr(); gRv = 1; gV = 2'b01; gDv = 2'b01; gD0 = 5;
      step("R9");
    end
    // R8: refill from the commit side, then reuse
    while (pqH < pqT) begin
      clr(); gAuto = 1;
      step("R8");
    end
    clr(); gRv = 1; gV = 2'b11; gDv = 2'b11; gD0 = 7; gD1 = 6;
    step("R8");

    // R10: fill all checkpoint slots; the fifth branch stalls
    for (int i = 0; i < 5; i++) begin
      clr(); gRv = 1; gV = 2'b11; gDv = 2'b11; gBr = 1;
      gD0 = 1 + i; gD1 = 2 + i; gA0 = 1 + i;
      step("R10");
    end
    for (int i = 0; i < 2; i++) begin
      clr(); gRv = 1; gV = 2'b11; gDv = 2'b11; gD0 = 1 + i; gD1 = 3;
      step("");
    end
    // R13: restore slot 1 while a group is offered
    clr(); gRv = 1; gV = 2'b11; gDv = 2'b11; gD0 = 1; gD1 = 2; gRs = 1; gRt = 1;
    gFv = 2'b01; gF0 = 17;
    step("R13");
    // R11: map and reissue order after the restore
    for (int s = 0; s < 4; s++) begin
      clr(); gRv = 1; gV = 2'b11;
      gA0 = 2 * s; gB0 = 2 * s + 1; gA1 = 7 - 2 * s; gB1 = 6 - 2 * s;
      step("R11");
    end
    for (int i = 0; i < 3; i++) begin
      clr(); gRv = 1; gV = 2'b11; gDv = 2'b11; gD0 = 3 + i; gD1 = 4 + i;
      step("R11");
    end
    // R12: squashed slots are reusable, lowest first
    for (int i = 0; i < 2; i++) begin
      clr(); gRv = 1; gV = 2'b01; gDv = 2'b01; gBr = 1; gD0 = 1 + i;
      step("R12");
    end
    clr(); gRl = 1; gLt = 0;
    step("R12");
    clr(); gRv = 1; gV = 2'b01; gDv = 2'b01; gBr = 1; gD0 = 6;
    step("R12");
    clr(); gRs = 1; gRt = 0;
    step("R12");
    for (int i = 0; i < 5; i++) begin
      clr(); gRv = 1; gV = 2'b11; gDv = 2'b10; gBr = 1; gD1 = 2 + i;
      step("R12");
    end

    summary();
    $finish;
  end

endmodule